// File: doc/BRIEF.md
# Row-Locality-Aware Hybrid Placement Monitor

This block sits beside the controller of a large, slow memory that has a small, fast memory caching it. It receives one report per access (row address, whether the access found its row already open in the row buffer, and a valid strobe) and decides which rows are worth moving into the fast memory. Both technologies serve an open-row access at roughly the same speed; only a closed-row access is far slower in the slow memory. Rows that keep missing in the row buffer are therefore the ones to promote. Rows read in a streaming fashion, which almost always find their row open, are left where they are.

A small direct-mapped table keeps one miss counter per slot. The slot is chosen by the low row-address bits, and the remaining bits form a tag. When a counter reaches the promotion threshold, the block issues one migration request through a single-entry output buffer with a valid/ready handshake and then clears that counter. Requiring several misses is also the reuse test: a row touched only once never qualifies. A programmable epoch clears all history at regular intervals. In the adaptive mode, the threshold moves by one step at each epoch end, depending on how many promotions that epoch produced.

Top module: `rlp_placement_monitor`

## Requirements
- R1: A valid closed-row access (acc_hit=0) to a row whose slot (acc_row[2:0] with default parameters) already holds its tag adds one to that slot's count. When the count reaches the active threshold, mig_valid is high with mig_row equal to that row right after the same clock edge.
- R2: Open-row accesses (acc_hit=1) and reports with acc_valid=0 never change any count and never cause a promotion.
- R3: A closed-row access whose tag differs from the one held in its slot replaces that slot's entry and restarts its count at 1.
- R4: After a promotion, the slot's count is zero, so the same row needs a full threshold's worth of new misses before it is promoted again.
- R5: With cfg_epoch_len=N (N>0), the table is emptied at the clock edge that ends every N-th cycle after reset. A closed-row access arriving in that same cycle is not counted. cfg_epoch_len=0 disables epochs.
- R6: While mig_valid=1 and mig_ready=0, mig_valid stays high and mig_row does not change.
- R7: A promotion that arrives while the buffer is full and not being drained is dropped, and drop_count goes up by one (saturating). A promotion that arrives in the cycle the buffer is drained replaces the old entry and is not counted as dropped.
- R8: With cfg_dyn=1, at each epoch end the threshold goes up by one (saturating at 2^CNT_W-1) when that epoch's promotions exceeded cfg_budget.
- R9: With cfg_dyn=1, at each epoch end that had no promotions, the threshold goes down by one, but never below 1.
- R10: With cfg_dyn=0, the active threshold shown on cur_thresh is cfg_thresh, and a value of 0 is treated as 1. A switch into adaptive mode starts from this value.
- R11: After reset, mig_valid=0, drop_count=0 and the table is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access report strobe |
| acc_hit | input | 1 | 1 = row was already open in the row buffer |
| acc_row | input | ROW_W | Row address of the access |
| cfg_thresh | input | CNT_W | Static promotion threshold |
| cfg_dyn | input | 1 | 1 = adaptive threshold |
| cfg_epoch_len | input | EP_W | Epoch length in cycles, 0 = no epochs |
| cfg_budget | input | BUD_W | Promotions per epoch above which the threshold rises |
| mig_valid | output | 1 | Migration request pending |
| mig_ready | input | 1 | Consumer takes the request |
| mig_row | output | ROW_W | Row to migrate |
| cur_thresh | output | CNT_W | Active threshold |
| drop_count | output | DROP_W | Saturating count of dropped promotions |

## Verification
The bench targets slot aliasing. Two rows sharing a slot must not pool their misses; a design that ignored the tag would promote a row after fewer of its own misses than the threshold. Interleaved open-row accesses test whether hits leak into the count, which would promote streaming rows. The bench checks that the count restarts after a promotion and after an epoch clear; a stale count would cause an early second promotion. The full-buffer case checks that the held request stays stable, that a promotion arriving during a stall is counted as dropped, and that one arriving while the buffer drains is accepted. The adaptive threshold is followed through a rise, two falls and the floor at 1, so an off-by-one or an underflow to zero shows up on cur_thresh.

// File: rtl/rlp_pkg.sv
`timescale 1ns/1ps
package rlp_pkg;

  // a threshold of zero would promote on nothing; treat it as one
  function automatic int rlp_floor_thr(int t);
    return (t < 1) ? 1 : t;
  endfunction

  // one adaptive step taken at an epoch boundary
  function automatic int rlp_next_thr(int thr, int promos, int budget, int cap);
    if (promos > budget) return (thr >= cap) ? cap : thr + 1;
    if (promos == 0)     return (thr <= 1) ? 1 : thr - 1;
    return thr;
  endfunction

  function automatic int rlp_sat_inc(int v, int cap);
    return (v >= cap) ? cap : v + 1;
  endfunction

endpackage

// File: rtl/rlp_miss_table.sv
`timescale 1ns/1ps
module rlp_miss_table #(
  parameter int ROW_W = 16,
  parameter int IDX_W = 3,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic             acc_hit,
  input  logic [ROW_W-1:0] acc_row,
  input  logic [CNT_W-1:0] thresh,
  input  logic             clear,
  output logic             promote,
  output logic [ROW_W-1:0] promote_row
);
  localparam int TAG_W = ROW_W - IDX_W;
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0] vld_q;
  logic [TAG_W-1:0] tag_q [DEPTH];
  logic [CNT_W-1:0] cnt_q [DEPTH];

  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;
  logic             match;
  logic             count_ev;
  logic [CNT_W-1:0] next_cnt;

  always_comb begin
    idx      = acc_row[IDX_W-1:0];
    tag      = acc_row[ROW_W-1:IDX_W];
    match    = vld_q[idx] && (tag_q[idx] == tag);
    count_ev = acc_valid && !acc_hit && !clear;
    next_cnt = match ? (cnt_q[idx] + CNT_W'(1)) : CNT_W'(1);
    promote  = count_ev && (next_cnt >= thresh);
  end

  assign promote_row = acc_row;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        tag_q[i] <= '0;
        cnt_q[i] <= '0;
      end
    end else if (clear) begin
      vld_q <= '0;
    end else if (count_ev) begin
      vld_q[idx] <= 1'b1;
      tag_q[idx] <= tag;
      cnt_q[idx] <= promote ? '0 : next_cnt;
    end
  end

  // R3: a fresh occupant starts counting at one
  a_r3_fresh_starts_at_one: assert property (@(posedge clk) disable iff (!rst_n)
    (count_ev && !match && !promote) |=> (vld_q[$past(idx)] && cnt_q[$past(idx)] == CNT_W'(1)));

  // R4: promotion leaves the slot at zero
  a_r4_zero_after_promote: assert property (@(posedge clk) disable iff (!rst_n)
    promote |=> (cnt_q[$past(idx)] == '0));

  // R5: epoch clear empties the table
  a_r5_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (vld_q == '0));

  // R2: a row-buffer hit never leads to promotion
  a_r2_hit_no_promote: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_hit) |-> !promote);

endmodule

// File: rtl/rlp_epoch_ctrl.sv
`timescale 1ns/1ps
module rlp_epoch_ctrl
  import rlp_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int EP_W  = 16,
  parameter int BUD_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EP_W-1:0]  cfg_epoch_len,
  input  logic             cfg_dyn,
  input  logic [CNT_W-1:0] cfg_thresh,
  input  logic [BUD_W-1:0] cfg_budget,
  input  logic             promote,
  output logic             epoch_end,
  output logic [CNT_W-1:0] thresh
);
  localparam int CNT_MAX = (1 << CNT_W) - 1;
  localparam int BUD_MAX = (1 << BUD_W) - 1;

  logic [EP_W-1:0]  ep_q;
  logic [BUD_W-1:0] pcnt_q;
  logic [CNT_W-1:0] thr_q;
  logic [CNT_W-1:0] static_thr;
  logic [CNT_W-1:0] adapt_thr;

  assign epoch_end  = (cfg_epoch_len != '0) && (ep_q >= cfg_epoch_len - EP_W'(1));
  assign static_thr = CNT_W'(rlp_floor_thr(int'(cfg_thresh)));
  assign adapt_thr  = CNT_W'(rlp_next_thr(int'(thr_q), int'(pcnt_q), int'(cfg_budget), CNT_MAX));
  assign thresh     = cfg_dyn ? thr_q : static_thr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ep_q   <= '0;
      pcnt_q <= '0;
      thr_q  <= CNT_W'(1);
    end else begin
      if (cfg_epoch_len == '0 || epoch_end) ep_q <= '0;
      else                                  ep_q <= ep_q + EP_W'(1);

      if (epoch_end)    pcnt_q <= '0;
      else if (promote) pcnt_q <= BUD_W'(rlp_sat_inc(int'(pcnt_q), BUD_MAX));

      if (!cfg_dyn)       thr_q <= static_thr;
      else if (epoch_end) thr_q <= adapt_thr;
    end
  end

  // R9: adaptive threshold never falls to zero
  a_r9_floor: assert property (@(posedge clk) disable iff (!rst_n)
    thr_q != '0);

  // R8: adaptive threshold only moves at an epoch boundary
  a_r8_moves_at_epoch_only: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_dyn && !epoch_end) |=> $stable(thr_q));

  // R8: busy epoch raises threshold by exactly one
  a_r8_rise_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_dyn && epoch_end && (int'(pcnt_q) > int'(cfg_budget)) && (int'(thr_q) < CNT_MAX))
      |=> (thr_q == $past(thr_q) + CNT_W'(1)));

endmodule

// File: rtl/rlp_mig_buf.sv
`timescale 1ns/1ps
module rlp_mig_buf
  import rlp_pkg::*;
#(
  parameter int ROW_W  = 16,
  parameter int DROP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [ROW_W-1:0]  push_row,
  input  logic              mig_ready,
  output logic              mig_valid,
  output logic [ROW_W-1:0]  mig_row,
  output logic [DROP_W-1:0] drop_count
);
  localparam int DROP_MAX = (1 << DROP_W) - 1;

  logic              mv_q;
  logic [ROW_W-1:0]  row_q;
  logic [DROP_W-1:0] drop_q;
  logic              accept;
  logic              drop;

  assign accept = push && (!mv_q || mig_ready);
  assign drop   = push && mv_q && !mig_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mv_q   <= 1'b0;
      row_q  <= '0;
      drop_q <= '0;
    end else begin
      if (accept) begin
        mv_q  <= 1'b1;
        row_q <= push_row;
      end else if (mig_ready) begin
        mv_q  <= 1'b0;
      end
      if (drop) drop_q <= DROP_W'(rlp_sat_inc(int'(drop_q), DROP_MAX));
    end
  end

  assign mig_valid  = mv_q;
  assign mig_row    = row_q;
  assign drop_count = drop_q;

  // R6: stalled request is held unchanged
  a_r6_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_q && !mig_ready) |=> (mv_q && $stable(row_q)));

  // R1: accepted promotion appears on the output
  a_r1_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    (push && (!mv_q || mig_ready)) |=> (mv_q && row_q == $past(push_row)));

  // R7: drop counter moves only for a blocked promotion
  a_r7_count_only_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && mv_q && !mig_ready) |=> $stable(drop_q));

endmodule

// File: rtl/rlp_placement_monitor.sv
`timescale 1ns/1ps
module rlp_placement_monitor #(
  parameter int ROW_W  = 16,
  parameter int IDX_W  = 3,
  parameter int CNT_W  = 4,
  parameter int EP_W   = 16,
  parameter int BUD_W  = 8,
  parameter int DROP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_hit,
  input  logic [ROW_W-1:0]  acc_row,
  input  logic [CNT_W-1:0]  cfg_thresh,
  input  logic              cfg_dyn,
  input  logic [EP_W-1:0]   cfg_epoch_len,
  input  logic [BUD_W-1:0]  cfg_budget,
  output logic              mig_valid,
  input  logic              mig_ready,
  output logic [ROW_W-1:0]  mig_row,
  output logic [CNT_W-1:0]  cur_thresh,
  output logic [DROP_W-1:0] drop_count
);
  logic             promote;
  logic [ROW_W-1:0] promote_row;
  logic             epoch_end;
  logic [CNT_W-1:0] thresh;

  rlp_miss_table #(.ROW_W(ROW_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(acc_valid), .acc_hit(acc_hit), .acc_row(acc_row),
    .thresh(thresh), .clear(epoch_end),
    .promote(promote), .promote_row(promote_row)
  );

  rlp_epoch_ctrl #(.CNT_W(CNT_W), .EP_W(EP_W), .BUD_W(BUD_W)) u_epoch (
    .clk(clk), .rst_n(rst_n),
    .cfg_epoch_len(cfg_epoch_len), .cfg_dyn(cfg_dyn),
    .cfg_thresh(cfg_thresh), .cfg_budget(cfg_budget),
    .promote(promote), .epoch_end(epoch_end), .thresh(thresh)
  );

  rlp_mig_buf #(.ROW_W(ROW_W), .DROP_W(DROP_W)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .push(promote), .push_row(promote_row), .mig_ready(mig_ready),
    .mig_valid(mig_valid), .mig_row(mig_row), .drop_count(drop_count)
  );

  assign cur_thresh = thresh;

  // R11: nothing pending in the first cycle after reset
  a_r11_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !mig_valid);

endmodule

// File: tb/test_rlp_placement_monitor.sv
`timescale 1ns/1ps
module test_rlp_placement_monitor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0, acc_hit = 1'b0;
  logic [15:0] acc_row = '0;
  logic [3:0]  cfg_thresh = 4'd3;
  logic        cfg_dyn = 1'b0;
  logic [15:0] cfg_epoch_len = '0;
  logic [7:0]  cfg_budget = '0;
  logic        mig_ready = 1'b1;
  logic        mig_valid;
  logic [15:0] mig_row;
  logic [3:0]  cur_thresh;
  logic [7:0]  drop_count;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rlp_placement_monitor i_rlp_placement_monitor (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_hit(acc_hit),
    .acc_row(acc_row), .cfg_thresh(cfg_thresh), .cfg_dyn(cfg_dyn),
    .cfg_epoch_len(cfg_epoch_len), .cfg_budget(cfg_budget),
    .mig_valid(mig_valid), .mig_ready(mig_ready), .mig_row(mig_row),
    .cur_thresh(cur_thresh), .drop_count(drop_count)
  );

  // {valid, hit, row, expected mig_valid, expected mig_row}; threshold 3, no epochs
  localparam logic [34:0] VEC [16] = '{
    {1'b1, 1'b0, 16'h0011, 1'b0, 16'h0000},  // R1 count 1
    {1'b1, 1'b1, 16'h0011, 1'b0, 16'h0000},  // R2 hit
    {1'b1, 1'b1, 16'h0011, 1'b0, 16'h0000},  // R2 hit
    {1'b1, 1'b0, 16'h0011, 1'b0, 16'h0000},  // count 2
    {1'b1, 1'b0, 16'h0011, 1'b1, 16'h0011},  // R1 promote
    {1'b1, 1'b0, 16'h0011, 1'b0, 16'h0000},  // R4 restart at 1
    {1'b1, 1'b0, 16'h0011, 1'b0, 16'h0000},  // count 2
    {1'b1, 1'b0, 16'h0109, 1'b0, 16'h0000},  // R3 alias evicts
    {1'b1, 1'b0, 16'h0011, 1'b0, 16'h0000},  // R3 back to 1
    {1'b1, 1'b0, 16'h0011, 1'b0, 16'h0000},  // 2
    {1'b1, 1'b0, 16'h0022, 1'b0, 16'h0000},  // other slot 1
    {1'b1, 1'b0, 16'h0011, 1'b1, 16'h0011},  // promote
    {1'b1, 1'b0, 16'h0022, 1'b0, 16'h0000},  // 2
    {1'b0, 1'b0, 16'h0022, 1'b0, 16'h0000},  // R2 invalid report
    {1'b1, 1'b0, 16'h0022, 1'b1, 16'h0022},  // promote
    {1'b0, 1'b0, 16'h0000, 1'b0, 16'h0000}   // drained
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic h, input logic [15:0] r);
    acc_valid = v; acc_hit = h; acc_row = r;
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; acc_valid = 1'b0; acc_hit = 1'b0; acc_row = '0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // reset state
    cfg_thresh = 4'd3; mig_ready = 1'b1;
    do_reset();
    chk("R11 mig_valid", 32'(mig_valid), 0);
    chk("R11 drop_count", 32'(drop_count), 0);
    chk("R10 cur_thresh", 32'(cur_thresh), 3);

    // vector walk
    for (int i = 0; i < 16; i++) begin
      drive(VEC[i][34], VEC[i][33], VEC[i][32:17]);
      chk($sformatf("R1 vec%0d mig_valid", i), 32'(mig_valid), 32'(VEC[i][16]));
      if (VEC[i][16]) chk($sformatf("R1 vec%0d mig_row", i), 32'(mig_row), 32'(VEC[i][15:0]));
    end

    // zero threshold acts as one; full buffer drops
    cfg_thresh = 4'd0; mig_ready = 1'b0;
    do_reset();
    chk("R10 zero thresh", 32'(cur_thresh), 1);
    drive(1, 0, 16'h0101);
    chk("R10 single miss promotes", 32'(mig_valid), 1);
    chk("R1 row", 32'(mig_row), 32'h0101);
    drive(1, 0, 16'h0202);
    chk("R7 drop counted", 32'(drop_count), 1);
    chk("R6 row held", 32'(mig_row), 32'h0101);
    chk("R6 valid held", 32'(mig_valid), 1);
    mig_ready = 1'b1;
    drive(1, 0, 16'h0303);
    chk("R7 accept while draining", 32'(mig_row), 32'h0303);
    chk("R7 no drop while draining", 32'(drop_count), 1);
    drive(0, 0, 16'h0000);
    chk("R6 popped", 32'(mig_valid), 0);

    // epoch clear: epoch of 8 cycles, threshold 3
    cfg_thresh = 4'd3; cfg_epoch_len = 16'd8;
    do_reset();
    drive(1, 0, 16'h0033);
    drive(1, 0, 16'h0033);
    repeat (6) drive(0, 0, 16'h0000);
    drive(1, 0, 16'h0033);
    chk("R5 history cleared", 32'(mig_valid), 0);
    drive(1, 0, 16'h0033);
    chk("R5 second after clear", 32'(mig_valid), 0);
    drive(1, 0, 16'h0033);
    chk("R5 third after clear promotes", 32'(mig_valid), 1);

    // adaptive threshold
    cfg_thresh = 4'd2; cfg_budget = 8'd0; cfg_dyn = 1'b0;
    do_reset();
    drive(0, 0, 16'h0000);
    cfg_dyn = 1'b1;
    drive(1, 0, 16'h0044);
    drive(1, 0, 16'h0044);
    chk("R8 promotion in epoch", 32'(mig_valid), 1);
    repeat (4) drive(0, 0, 16'h0000);
    chk("R10 start value", 32'(cur_thresh), 2);
    drive(0, 0, 16'h0000);
    chk("R8 raised", 32'(cur_thresh), 3);
    repeat (8) drive(0, 0, 16'h0000);
    chk("R9 lowered", 32'(cur_thresh), 2);
    repeat (8) drive(0, 0, 16'h0000);
    chk("R9 lowered to one", 32'(cur_thresh), 1);
    repeat (8) drive(0, 0, 16'h0000);
    chk("R9 floor", 32'(cur_thresh), 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule